// File: doc/BRIEF.md
# Core Clock Rate-Change Sequencer

This block runs a coordinated frequency change for a processor clock domain. While the domain's main PLL is being reprogrammed, the core clock has to run from a second source. The sequencer moves the core clock to that alternate source and sets the domain dividers for the target rate. Later it moves the core clock back to the main source. It drives a simple masked register-write port toward the clock mux and divider block, and it watches that block's mux status and divider busy flags.

A request carries a phase (pre or post), the old rate, the new rate and the alternate-source rate, all in Hz. In the pre phase the sequencer searches a small configuration table for the target rate. Each table entry holds a rate in kHz and two packed divider words. If needed, the sequencer computes a safe core ratio by iterative subtraction. This ratio keeps the core clock at or below the lower of the old and new rates while the alternate source is active. Every status wait is bounded by a cycle counter. When the counter runs out, the sequencer raises a flag and moves on instead of stalling.

Top module: `core_clk_shift_seq`

## Requirements
- R1: After reset, busy, done, wr_en, err_inval, err_timeout and warn_div are all low.
- R2: A request with req_valid high is accepted only when the block is idle, and busy rises in the next cycle. A req_valid pulse while busy is high has no effect on the write sequence or on the flags.
- R3: In the pre phase (req_post = 0), the sequencer scans entries from index 0 and matches when entry kHz times 1000 equals new_rate. An entry with kHz = 0, or running past the last entry, ends the scan: err_inval is set, done pulses, and no write is issued.
- R4: A safe ratio is used only when alt_rate > old_rate or old_rate > new_rate. Otherwise the first write of the pre phase is the mux write.
- R5: The safe ratio equals ceil(alt_rate / min(old_rate, new_rate)) - 1. It is written to the ratio field at bits 2:0 of divider register 0 (wr_addr = 1) with mask 0x7. A value of 8 or more sets warn_div and is written as 7.
- R6: The pre phase issues writes in this order: the safe write if needed, waiting until the masked div0_busy bits are clear; a mux write (wr_addr = 0, mask 0x1, data 1), waiting for mux_stat = 2; a full-word write of the entry's divider-0 word OR-ed with the safe ratio, waiting for div0_busy = 0; and, only when opt_div1 is set, a full-word write of the entry's divider-1 word to wr_addr = 2, waiting for div1_busy = 0.
- R7: When opt_dbg_div is set, the debug-bus divider field at bits 18:16 joins both partial writes, and the mask becomes 0x70007. In the safe write that field is 7. In the post-phase restore write it takes the entry's bits 18:16, which the post phase finds by the same table scan.
- R8: The post phase (req_post = 1) writes the mux with mask 0x1 and data 0, waits for mux_stat = 1, then writes 0 to the ratio field of divider register 0 (mask 0x7 when the option is off) and waits for those busy bits to clear.
- R9: A status wait that does not finish within TIMEOUT cycles sets err_timeout, and the sequence continues to its end.
- R10: done is a single-cycle pulse during the last busy cycle. Busy is low in the cycle after done. The flags hold until the next accepted request.
- R11: No divider write is issued while the mux status shows a source change in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_post | input | 1 | Phase: 0 pre-change, 1 post-change |
| old_rate | input | RATE_W | Current main-source rate in Hz |
| new_rate | input | RATE_W | Target main-source rate in Hz |
| alt_rate | input | RATE_W | Alternate-source rate in Hz |
| opt_dbg_div | input | 1 | Include the debug-bus divider field in the partial writes |
| opt_div1 | input | 1 | A second divider register is present |
| tbl_khz | input | TBL_N*KHZ_W | Entry rates in kHz, entry 0 in the low bits |
| tbl_div0 | input | TBL_N*32 | Divider-0 words per entry |
| tbl_div1 | input | TBL_N*32 | Divider-1 words per entry |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | 0 mux select, 1 divider 0, 2 divider 1 |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Bits of the register that the write changes |
| mux_stat | input | 3 | Mux status: 1 main source, 2 alternate, other values in transition |
| div0_busy | input | 32 | Divider-0 busy bits |
| div1_busy | input | 32 | Divider-1 busy bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| err_inval | output | 1 | No table entry matched the target rate |
| err_timeout | output | 1 | A status wait expired |
| warn_div | output | 1 | Safe ratio exceeded the 3-bit field |

## Verification
The pre phase is tried with a rising change where the alternate source is slower, which must skip the safe write. It is also tried with a falling change, which must add it, and with a slow old rate under a faster alternate source, where the division is exact so that a floor or ceiling error shows up. A ten-fold alternate source separates correct saturation and warning from wrap-around, and an unmatched rate shows that the scan stops at the terminator. Post-phase runs with and without the debug option check both restore masks, and a status model that never clears its busy bits checks that each expired wait moves the sequence on. The status model answers after random delays, so the bench also confirms that the sequencer waits for the right status values and never writes a divider while the mux is changing.

// File: rtl/core_clk_shift_pkg.sv
package core_clk_shift_pkg;

    typedef enum logic [1:0] {
        REG_MUX  = 2'd0,
        REG_DIV0 = 2'd1,
        REG_DIV1 = 2'd2
    } reg_sel_e;

    typedef enum logic [4:0] {
        S_IDLE, S_LOOKUP, S_DIV_GO, S_DIV_RUN,
        S_SAFE_WR, S_SAFE_WT, S_MUX_WR, S_MUX_WT,
        S_D0_WR, S_D0_WT, S_D1_WR, S_D1_WT,
        S_PMUX_WR, S_PMUX_WT, S_PDIV_WR, S_PDIV_WT, S_FIN
    } seq_state_e;

    localparam logic [31:0] RATIO_FIELD = 32'h0000_0007;
    localparam logic [31:0] DBG_FIELD   = 32'h0007_0000;
    localparam logic [2:0]  MUX_ON_ALT  = 3'd2;
    localparam logic [2:0]  MUX_ON_MAIN = 3'd1;

endpackage

// File: rtl/cks_ceil_div.sv
module cks_ceil_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [2:0]   quot,
    output logic         warn
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] rem;
        logic [3:0]   cnt;
        logic         done;
    } dv_t;

    dv_t d_d, d_q;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        if (start) begin
            d_d.run = 1'b1;
            d_d.rem = num;
            d_d.cnt = '0;
        end else if (d_q.run) begin
            if (d_q.rem > den && !d_q.cnt[3]) begin
                d_d.rem = d_q.rem - den;
                d_d.cnt = d_q.cnt + 4'd1;
            end else begin
                d_d.run  = 1'b0;
                d_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign done = d_q.done;
    assign warn = d_q.cnt[3];
    assign quot = d_q.cnt[3] ? 3'd7 : d_q.cnt[2:0];
endmodule

// File: rtl/cks_wait_timer.sv
module cks_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb cnt_d = run ? cnt_q + CW'(1) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/core_clk_shift_seq.sv
module core_clk_shift_seq
    import core_clk_shift_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int KHZ_W   = 22,
    parameter int TBL_N   = 4,
    parameter int TIMEOUT = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_post,
    input  logic [RATE_W-1:0]       old_rate,
    input  logic [RATE_W-1:0]       new_rate,
    input  logic [RATE_W-1:0]       alt_rate,
    input  logic                    opt_dbg_div,
    input  logic                    opt_div1,
    input  logic [TBL_N*KHZ_W-1:0]  tbl_khz,
    input  logic [TBL_N*32-1:0]     tbl_div0,
    input  logic [TBL_N*32-1:0]     tbl_div1,
    output logic                    wr_en,
    output logic [1:0]              wr_addr,
    output logic [31:0]             wr_data,
    output logic [31:0]             wr_mask,
    input  logic [2:0]              mux_stat,
    input  logic [31:0]             div0_busy,
    input  logic [31:0]             div1_busy,
    output logic                    busy,
    output logic                    done,
    output logic                    err_inval,
    output logic                    err_timeout,
    output logic                    warn_div
);
    localparam int IW = $clog2(TBL_N + 1);
    localparam int PW = RATE_W + KHZ_W;

    typedef struct packed {
        seq_state_e        st;
        logic              post;
        logic              dbg;
        logic              div1;
        logic [RATE_W-1:0] old_r;
        logic [RATE_W-1:0] new_r;
        logic [RATE_W-1:0] alt_r;
        logic [IW-1:0]     idx;
        logic [2:0]        safe;
        logic [31:0]       e0;
        logic [31:0]       e1;
        logic              inval;
        logic              tmo;
        logic              warn;
    } seq_t;

    seq_t q, n;

    logic              tmr_run, tmr_exp, dv_start, dv_done, dv_warn;
    logic [2:0]        dv_quot;
    logic [RATE_W-1:0] min_rate;
    logic              need_safe, idx_end, hit, ok;
    logic [IW-1:0]     idx_c;
    logic [KHZ_W-1:0]  cur_khz;
    logic [PW-1:0]     prod;
    logic [31:0]       part_mask;
    seq_state_e        nxt;

    assign min_rate  = (q.old_r < q.new_r) ? q.old_r : q.new_r;
    assign need_safe = (q.alt_r > q.old_r) || (q.old_r > q.new_r);
    assign idx_end   = (q.idx >= IW'(TBL_N));
    assign idx_c     = idx_end ? '0 : q.idx;
    assign cur_khz   = tbl_khz[idx_c*KHZ_W +: KHZ_W];
    assign prod      = {{RATE_W{1'b0}}, cur_khz} * PW'(1000);
    assign hit       = (prod == {{KHZ_W{1'b0}}, q.new_r});
    assign part_mask = RATIO_FIELD | (q.dbg ? DBG_FIELD : 32'h0);

    cks_ceil_div #(.W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(dv_start), .num(q.alt_r),
        .den(min_rate), .done(dv_done), .quot(dv_quot), .warn(dv_warn)
    );

    cks_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_exp)
    );

    always_comb begin
        n        = q;
        tmr_run  = 1'b0;
        dv_start = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = REG_MUX;
        wr_data  = '0;
        wr_mask  = '0;
        ok       = 1'b0;
        nxt      = S_FIN;
        case (q.st)
            S_IDLE: if (req_valid) begin
                n.post  = req_post;
                n.dbg   = opt_dbg_div;
                n.div1  = opt_div1;
                n.old_r = old_rate;
                n.new_r = new_rate;
                n.alt_r = alt_rate;
                n.idx   = '0;
                n.safe  = '0;
                n.inval = 1'b0;
                n.tmo   = 1'b0;
                n.warn  = 1'b0;
                n.st    = (req_post && !opt_dbg_div) ? S_PMUX_WR : S_LOOKUP;
            end
            S_LOOKUP: begin
                if (idx_end || cur_khz == '0) begin
                    n.inval = 1'b1;
                    n.st    = S_FIN;
                end else if (hit) begin
                    n.e0 = tbl_div0[idx_c*32 +: 32];
                    n.e1 = tbl_div1[idx_c*32 +: 32];
                    if (q.post)         n.st = S_PMUX_WR;
                    else if (need_safe) n.st = S_DIV_GO;
                    else                n.st = S_MUX_WR;
                end else begin
                    n.idx = q.idx + IW'(1);
                end
            end
            S_DIV_GO: begin
                dv_start = 1'b1;
                n.st     = S_DIV_RUN;
            end
            S_DIV_RUN: if (dv_done) begin
                n.safe = dv_quot;
                n.warn = dv_warn;
                n.st   = S_SAFE_WR;
            end
            S_SAFE_WR: begin
                wr_en   = 1'b1;
                wr_addr = REG_DIV0;
                wr_mask = part_mask;
                wr_data = (q.dbg ? DBG_FIELD : 32'h0) | {29'b0, q.safe};
                n.st    = S_SAFE_WT;
            end
            S_MUX_WR: begin
                wr_en   = 1'b1;
                wr_mask = 32'h1;
                wr_data = 32'h1;
                n.st    = S_MUX_WT;
            end
            S_D0_WR: begin
                wr_en   = 1'b1;
                wr_addr = REG_DIV0;
                wr_mask = '1;
                wr_data = q.e0 | {29'b0, q.safe};
                n.st    = S_D0_WT;
            end
            S_D1_WR: begin
                wr_en   = 1'b1;
                wr_addr = REG_DIV1;
                wr_mask = '1;
                wr_data = q.e1;
                n.st    = S_D1_WT;
            end
            S_PMUX_WR: begin
                wr_en   = 1'b1;
                wr_mask = 32'h1;
                n.st    = S_PMUX_WT;
            end
            S_PDIV_WR: begin
                wr_en   = 1'b1;
                wr_addr = REG_DIV0;
                wr_mask = part_mask;
                wr_data = q.dbg ? (q.e0 & DBG_FIELD) : 32'h0;
                n.st    = S_PDIV_WT;
            end
            S_SAFE_WT: begin ok = (div0_busy & part_mask) == '0; nxt = S_MUX_WR;  end
            S_MUX_WT:  begin ok = (mux_stat == MUX_ON_ALT);      nxt = S_D0_WR;   end
            S_D0_WT:   begin ok = (div0_busy == '0); nxt = q.div1 ? S_D1_WR : S_FIN; end
            S_D1_WT:   begin ok = (div1_busy == '0);             nxt = S_FIN;     end
            S_PMUX_WT: begin ok = (mux_stat == MUX_ON_MAIN);     nxt = S_PDIV_WR; end
            S_PDIV_WT: begin ok = (div0_busy & part_mask) == '0; nxt = S_FIN;     end
            S_FIN:     n.st = S_IDLE;
            default:   n.st = S_IDLE;
        endcase
        if (q.st inside {S_SAFE_WT, S_MUX_WT, S_D0_WT, S_D1_WT, S_PMUX_WT, S_PDIV_WT}) begin
            tmr_run = 1'b1;
            if (ok) begin
                n.st = nxt;
            end else if (tmr_exp) begin
                n.tmo = 1'b1;
                n.st  = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = (q.st == S_FIN);
    assign err_inval   = q.inval;
    assign err_timeout = q.tmo;
    assign warn_div    = q.warn;
endmodule

// File: rtl/cks_checker.sv
module cks_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] wr_mask,
    input logic        busy,
    input logic        done,
    input logic        err_inval,
    input logic        warn_div
);
    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_mux_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |-> (wr_mask == 32'h1));

    p_inval_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_inval |-> !wr_en);

    p_warn_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_mask != 32'hFFFF_FFFF && warn_div)
            |-> (wr_data[2:0] == 3'd7));
endmodule

bind core_clk_shift_seq cks_checker u_chk (.*);

// File: tb/core_clk_shift_seq_test.sv
module core_clk_shift_seq_test;
    localparam int RW = 32, KW = 22, N = 4, TMO = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_post = 1'b0, opt_dbg_div = 1'b0, opt_div1 = 1'b1;
    logic [RW-1:0] old_rate = '0, new_rate = '0, alt_rate = '0;
    logic [N*KW-1:0] tbl_khz;
    logic [N*32-1:0] tbl_div0, tbl_div1;
    logic wr_en, busy, done, err_inval, err_timeout, warn_div;
    logic [1:0] wr_addr;
    logic [31:0] wr_data, wr_mask;
    logic [2:0] mux_stat;
    logic [31:0] div0_busy, div1_busy;

    assign tbl_khz  = {22'd0, 22'd100000, 22'd400000, 22'd800000};
    assign tbl_div0 = {32'h0, 32'h0002_0000, 32'h0005_0100, 32'h0003_1210};
    assign tbl_div1 = {32'h0, 32'h0000_0011, 32'h0000_0023, 32'h0000_0045};

    always #2.5 clk = ~clk;

    core_clk_shift_seq #(.RATE_W(RW), .KHZ_W(KW), .TBL_N(N), .TIMEOUT(TMO)) uut (.*);

    // behavioural mux/divider block with random status latency
    logic mux_sel = 1'b0, stuck = 1'b0;
    int mcnt = 0, c0 = 0, c1 = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_stat <= 3'd1; div0_busy <= '0; div1_busy <= '0;
            mux_sel <= 1'b0; mcnt <= 0; c0 <= 0; c1 <= 0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: begin mux_sel <= wr_data[0]; mux_stat <= 3'd0; mcnt <= $urandom_range(1, 5); end
                2'd1: begin div0_busy <= wr_mask; c0 <= $urandom_range(1, 5); end
                default: begin div1_busy <= wr_mask; c1 <= $urandom_range(1, 5); end
            endcase
        end else begin
            if (mcnt != 0) begin
                mcnt <= mcnt - 1;
                if (mcnt == 1) mux_stat <= mux_sel ? 3'd2 : 3'd1;
            end
            if (c0 != 0) begin c0 <= c0 - 1; if (c0 == 1 && !stuck) div0_busy <= '0; end
            if (c1 != 0) begin c1 <= c1 - 1; if (c1 == 1 && !stuck) div1_busy <= '0; end
        end
    end

    // write log sampled away from the active edge
    logic [1:0]  lg_a [16];
    logic [31:0] lg_d [16], lg_m [16];
    int lg_n = 0, lg_mid = 0;
    always @(negedge clk) if (rst_n && wr_en) begin
        if (lg_n < 16) begin lg_a[lg_n] = wr_addr; lg_d[lg_n] = wr_data; lg_m[lg_n] = wr_mask; end
        lg_n = lg_n + 1;
        if (wr_addr != 2'd0 && mux_stat != 3'd1 && mux_stat != 3'd2) lg_mid = lg_mid + 1;
    end

    logic [1:0]  ex_a [16];
    logic [31:0] ex_d [16], ex_m [16];
    int ex_n = 0, n_chk = 0, n_bad = 0, cyc = 0, run_cyc = 0;

    task automatic chk(input string r, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
    endtask

    task automatic ex(input logic [1:0] a, input logic [31:0] d, input logic [31:0] m);
        ex_a[ex_n] = a; ex_d[ex_n] = d; ex_m[ex_n] = m; ex_n++;
    endtask

    function automatic logic [31:0] safe_of(input longint alt, input longint o, input longint nw);
        longint mn = (o < nw) ? o : nw;
        longint v = (alt + mn - 1) / mn - 1;
        return (v > 7) ? 32'd7 : 32'(v);
    endfunction

    task automatic cmp_log(input string r);
        chk(r, lg_n == ex_n, 32'(lg_n), 32'(ex_n));
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(r, lg_a[i] == ex_a[i] && lg_d[i] == ex_d[i] && lg_m[i] == ex_m[i],
                {lg_a[i], lg_d[i][29:0]}, {ex_a[i], ex_d[i][29:0]});
            if (lg_m[i] != ex_m[i]) $display("  mask actual=%0h expected=%0h", lg_m[i], ex_m[i]);
        end
        chk("R11", lg_mid == 0, 32'(lg_mid), 32'd0);
    endtask

    task automatic launch(input bit post, input int o, input int nw, input int alt);
        lg_n = 0; lg_mid = 0; ex_n = 0; run_cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_post = post; old_rate = o; new_rate = nw; alt_rate = alt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        while (!done && run_cyc < 3000) begin @(negedge clk); run_cyc++; end
        chk("R10", done == 1'b1, 32'(done), 32'd1);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R10", busy == 1'b0 && done == 1'b0, {30'b0, busy, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", !busy && !done && !wr_en && !err_inval && !err_timeout && !warn_div,
            {26'b0, busy, done, wr_en, err_inval, err_timeout, warn_div}, 32'd0);
    endtask

    task automatic t_up_no_safe();
        launch(1'b0, 400_000_000, 800_000_000, 200_000_000);
        chk("R2", busy == 1'b1, 32'(busy), 32'd1);
        finish_run();
        ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0003_1210, '1); ex(2'd2, 32'h45, '1);
        cmp_log("R4");
        chk("R3", !err_inval && !warn_div, {30'b0, err_inval, warn_div}, 32'd0);
        after_done();
    endtask

    task automatic t_down();
        logic [31:0] s = safe_of(1300_000_000, 800_000_000, 400_000_000);
        launch(1'b0, 800_000_000, 400_000_000, 1300_000_000);
        finish_run();
        ex(2'd1, s, 32'h7); ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0005_0100 | s, '1); ex(2'd2, 32'h23, '1);
        cmp_log("R6");
        chk("R5", s == 32'd3, s, 32'd3);
        after_done();
    endtask

    task automatic t_alt_exact();
        logic [31:0] s = safe_of(600_000_000, 200_000_000, 400_000_000);
        launch(1'b0, 200_000_000, 400_000_000, 600_000_000);
        finish_run();
        ex(2'd1, s, 32'h7); ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0005_0100 | s, '1); ex(2'd2, 32'h23, '1);
        cmp_log("R5");
        chk("R5", !warn_div, 32'(warn_div), 32'd0);
    endtask

    task automatic t_warn();
        launch(1'b0, 100_000_000, 100_000_000, 1000_000_000);
        finish_run();
        chk("R5", warn_div == 1'b1, 32'(warn_div), 32'd1);
        ex(2'd1, 32'h7, 32'h7); ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0002_0007, '1); ex(2'd2, 32'h11, '1);
        cmp_log("R5");
    endtask

    task automatic t_invalid();
        launch(1'b0, 400_000_000, 500_000_000, 200_000_000);
        finish_run();
        chk("R3", err_inval == 1'b1, 32'(err_inval), 32'd1);
        cmp_log("R3");
        after_done();
    endtask

    task automatic t_post();
        launch(1'b1, 800_000_000, 400_000_000, 1300_000_000);
        finish_run();
        ex(2'd0, 32'h0, 32'h1); ex(2'd1, 32'h0, 32'h7);
        cmp_log("R8");
        chk("R8", !err_inval && !err_timeout, {30'b0, err_inval, err_timeout}, 32'd0);
    endtask

    task automatic t_dbg();
        logic [31:0] s = safe_of(1300_000_000, 800_000_000, 400_000_000);
        opt_dbg_div = 1'b1; opt_div1 = 1'b0;
        launch(1'b0, 800_000_000, 400_000_000, 1300_000_000);
        finish_run();
        ex(2'd1, 32'h0007_0000 | s, 32'h0007_0007); ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0005_0100 | s, '1);
        cmp_log("R7");
        launch(1'b1, 800_000_000, 400_000_000, 1300_000_000);
        finish_run();
        ex(2'd0, 32'h0, 32'h1); ex(2'd1, 32'h0005_0000, 32'h0007_0007);
        cmp_log("R7");
        opt_dbg_div = 1'b0; opt_div1 = 1'b1;
    endtask

    task automatic t_busy_ignore();
        launch(1'b0, 400_000_000, 800_000_000, 200_000_000);
        @(negedge clk); @(negedge clk);
        chk("R2", busy == 1'b1, 32'(busy), 32'd1);
        req_valid = 1'b1; req_post = 1'b1; new_rate = 500_000_000; opt_dbg_div = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; opt_dbg_div = 1'b0;
        finish_run();
        ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0003_1210, '1); ex(2'd2, 32'h45, '1);
        cmp_log("R2");
        chk("R2", !err_inval, 32'(err_inval), 32'd0);
        after_done();
    endtask

    task automatic t_timeout();
        logic [31:0] s = safe_of(1300_000_000, 800_000_000, 400_000_000);
        stuck = 1'b1;
        launch(1'b0, 800_000_000, 400_000_000, 1300_000_000);
        finish_run();
        chk("R9", err_timeout == 1'b1, 32'(err_timeout), 32'd1);
        chk("R9", run_cyc >= 3 * TMO, 32'(run_cyc), 32'(3 * TMO));
        ex(2'd1, s, 32'h7); ex(2'd0, 32'h1, 32'h1); ex(2'd1, 32'h0005_0100 | s, '1); ex(2'd2, 32'h23, '1);
        cmp_log("R9");
        stuck = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_no_safe();
        t_down();
        t_alt_exact();
        t_warn();
        t_invalid();
        t_post();
        t_dbg();
        t_busy_ignore();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule